// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block picks, for a single processor, the most urgent interrupt that is both switched on and waiting. Each interrupt source supplies an enable bit, a pending bit and an 8-bit priority. Smaller priority numbers are more urgent. When two candidates share the same priority, the one with the smaller ID is chosen. One instance is placed per processor. The register decode, the acknowledge and completion flows, and any sharing of state between processors all sit outside this block.

The winning candidate then passes through two gates. The first gate compares it with a priority mask, and a candidate exactly at the mask still passes. The second gate compares it with the running priority of the interrupt already being served, and only a strictly more urgent candidate may preempt. The ID output shows the winner once it passes the mask. The request line rises only when the winner passes both gates. When nothing qualifies, the ID output shows the fixed spurious value 1023. A global distributor enable and a per-processor interface enable can each silence the block. Both outputs are registered.

Top module: `pend_prio_sel`

## Requirements
- R1: An interrupt is a candidate only when its `irqEnable` bit and its `irqPending` bit are both 1. An interrupt that is pending but not enabled is never reported.
- R2: Among the candidates, the one with the numerically smallest priority (field `irqPrio[8*i +: 8]` for interrupt i) is selected.
- R3: When several candidates share the smallest priority, the one with the lowest ID is selected.
- R4: When there is no candidate, `pendId` reads 1023 and `irqReq` is 0.
- R5: `pendId` shows the selected ID only when its priority is less than or equal to `prioMask`. Otherwise `pendId` reads 1023 and `irqReq` is 0.
- R6: `irqReq` is 1 only when the selected priority passes the mask and is also strictly less than `runPrio`. A priority equal to `runPrio` still publishes its ID but leaves `irqReq` at 0.
- R7: When `distEnable` or `cpuEnable` is 0, `pendId` reads 1023 and `irqReq` is 0.
- R8: Both outputs are registered. They reflect the inputs present at the previous rising clock edge, and an input change does not affect them before the next edge.
- R9: While `rst_n` is low, and right after reset, `pendId` is 1023 and `irqReq` is 0.
- R10: A `runPrio` of 0x100 means the processor is idle. In that case any published priority, including 0xFF, raises `irqReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| distEnable | input | 1 | Global distributor enable |
| cpuEnable | input | 1 | Enable for this processor's interface |
| irqEnable | input | NUM_IRQ | Per-interrupt enable bits |
| irqPending | input | NUM_IRQ | Per-interrupt pending bits |
| irqPrio | input | NUM_IRQ*8 | Priorities; interrupt i uses bits [8*i +: 8] |
| prioMask | input | 8 | Priority mask; passes when priority <= mask |
| runPrio | input | 9 | Running priority; 0x100 means idle |
| pendId | output | 10 | Highest pending ID, or 1023 when none |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the bound checker confirms four properties against the inputs captured at the previous edge:
- any published ID was enabled and pending,
- its priority is within the mask,
- no other candidate was more urgent or tied at a lower ID,
- a raised request implies strict preemption, and a disabled block stays silent.

Some behaviours can only be shown by the bench scenarios. These are the exact boundaries:
- a priority equal to the mask passes, while one just above it fails,
- a priority equal to the running priority does not preempt,
- an idle running priority accepts 0xFF.

The bench scenarios also cover the reset values and the fact that an input change does not appear before the next edge.

// File: rtl/pend_sel_pkg.sv
package pend_sel_pkg;
  localparam int SPURIOUS_ID = 1023;

  // Strobes from the gating control into the output datapath.
  typedef struct packed {
    logic publish;
    logic raise;
  } gate_t;
endpackage

// File: rtl/pend_sel_scan.sv
module pend_sel_scan #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic [NUM_IRQ-1:0]        irqEnable,
  input  logic [NUM_IRQ-1:0]        irqPending,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  output logic [PRIO_W:0]           bestPrio,
  output logic [ID_W-1:0]           bestId
);
  localparam logic [PRIO_W:0]   IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
  localparam logic [ID_W-1:0]   NONE_ID   = ID_W'(pend_sel_pkg::SPURIOUS_ID);

  logic [NUM_IRQ-1:0] cand;
  assign cand = irqEnable & irqPending;

  // Ascending scan; only a strictly smaller value replaces the best,
  // so the lowest ID wins among equal priorities.
  always_comb begin
    bestPrio = IDLE_PRIO;
    bestId   = NONE_ID;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && ({1'b0, irqPrio[i*PRIO_W +: PRIO_W]} < bestPrio)) begin
        bestPrio = {1'b0, irqPrio[i*PRIO_W +: PRIO_W]};
        bestId   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pend_sel_ctrl.sv
module pend_sel_ctrl #(
  parameter int PRIO_W = 8
) (
  input  logic                distEnable,
  input  logic                cpuEnable,
  input  logic [PRIO_W-1:0]   prioMask,
  input  logic [PRIO_W:0]     runPrio,
  input  logic [PRIO_W:0]     bestPrio,
  output pend_sel_pkg::gate_t gate
);
  logic enabled;
  logic maskPass;
  logic preempt;

  assign enabled  = distEnable & cpuEnable;
  assign maskPass = bestPrio <= {1'b0, prioMask};
  assign preempt  = bestPrio < runPrio;

  always_comb begin
    gate.publish = enabled & maskPass;
    gate.raise   = enabled & maskPass & preempt;
  end
endmodule

// File: rtl/pend_sel_outreg.sv
module pend_sel_outreg #(
  parameter int ID_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pend_sel_pkg::gate_t gate,
  input  logic [ID_W-1:0]     bestId,
  output logic [ID_W-1:0]     pendId,
  output logic                irqReq
);
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(pend_sel_pkg::SPURIOUS_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendId <= NONE_ID;
      irqReq <= 1'b0;
    end else begin
      pendId <= gate.publish ? bestId : NONE_ID;
      irqReq <= gate.raise;
    end
  end
endmodule

// File: rtl/pend_prio_sel.sv
module pend_prio_sel #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        distEnable,
  input  logic                        cpuEnable,
  input  logic [NUM_IRQ-1:0]          irqEnable,
  input  logic [NUM_IRQ-1:0]          irqPending,
  input  logic [NUM_IRQ*PRIO_W-1:0]   irqPrio,
  input  logic [PRIO_W-1:0]           prioMask,
  input  logic [PRIO_W:0]             runPrio,
  output logic [ID_W-1:0]             pendId,
  output logic                        irqReq
);
  logic [PRIO_W:0]     bestPrio;
  logic [ID_W-1:0]     bestId;
  pend_sel_pkg::gate_t gate;

  pend_sel_scan #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_scan (
    .irqEnable (irqEnable),
    .irqPending(irqPending),
    .irqPrio   (irqPrio),
    .bestPrio  (bestPrio),
    .bestId    (bestId)
  );

  pend_sel_ctrl #(.PRIO_W(PRIO_W)) u_ctrl (
    .distEnable(distEnable),
    .cpuEnable (cpuEnable),
    .prioMask  (prioMask),
    .runPrio   (runPrio),
    .bestPrio  (bestPrio),
    .gate      (gate)
  );

  pend_sel_outreg #(.ID_W(ID_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate),
    .bestId(bestId),
    .pendId(pendId),
    .irqReq(irqReq)
  );
endmodule

// File: rtl/pend_sel_checker.sv
module pend_sel_checker #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      distEnable,
  input logic                      cpuEnable,
  input logic [NUM_IRQ-1:0]        irqEnable,
  input logic [NUM_IRQ-1:0]        irqPending,
  input logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input logic [PRIO_W-1:0]         prioMask,
  input logic [PRIO_W:0]           runPrio,
  input logic [ID_W-1:0]           pendId,
  input logic                      irqReq
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] NONE_ID = ID_W'(pend_sel_pkg::SPURIOUS_ID);

  logic                      prevValid;
  logic                      prevDist, prevCpu;
  logic [NUM_IRQ-1:0]        prevEn, prevPend;
  logic [NUM_IRQ*PRIO_W-1:0] prevPrio;
  logic [PRIO_W-1:0]         prevMask;
  logic [PRIO_W:0]           prevRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevValid <= 1'b0;
      prevDist  <= 1'b0;
      prevCpu   <= 1'b0;
      prevEn    <= '0;
      prevPend  <= '0;
      prevPrio  <= '0;
      prevMask  <= '0;
      prevRun   <= '0;
    end else begin
      prevValid <= 1'b1;
      prevDist  <= distEnable;
      prevCpu   <= cpuEnable;
      prevEn    <= irqEnable;
      prevPend  <= irqPending;
      prevPrio  <= irqPrio;
      prevMask  <= prioMask;
      prevRun   <= runPrio;
    end
  end

  logic             published;
  logic [IDX_W-1:0] idx;
  logic [PRIO_W-1:0] chosenPrio;
  logic             betterExists;

  assign published  = prevValid && (pendId != NONE_ID) && (pendId < ID_W'(NUM_IRQ));
  assign idx        = pendId[IDX_W-1:0];
  assign chosenPrio = prevPrio[idx*PRIO_W +: PRIO_W];

  always_comb begin
    betterExists = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (prevEn[i] && prevPend[i]) begin
        if ((prevPrio[i*PRIO_W +: PRIO_W] < chosenPrio) ||
            ((prevPrio[i*PRIO_W +: PRIO_W] == chosenPrio) && (ID_W'(i) < pendId)))
          betterExists = 1'b1;
      end
    end
  end

  assert_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && pendId != NONE_ID) |-> (published && prevEn[idx] && prevPend[idx]));

  assert_best_R2: assert property (@(posedge clk) disable iff (!rst_n)
    published |-> !betterExists);

  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    published |-> (chosenPrio <= prevMask));

  assert_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && irqReq) |-> (published && ({1'b0, chosenPrio} < prevRun)));

  assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && !(prevDist && prevCpu)) |-> (!irqReq && pendId == NONE_ID));
endmodule

bind pend_prio_sel pend_sel_checker #(
  .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .distEnable(distEnable),
  .cpuEnable (cpuEnable),
  .irqEnable (irqEnable),
  .irqPending(irqPending),
  .irqPrio   (irqPrio),
  .prioMask  (prioMask),
  .runPrio   (runPrio),
  .pendId    (pendId),
  .irqReq    (irqReq)
);

// File: tb/pend_prio_sel_bench.sv
module pend_prio_sel_bench;
  localparam int N  = 64;
  localparam int PW = 8;
  localparam int IW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic distEnable = 1'b0, cpuEnable = 1'b0;
  logic [N-1:0] irqEnable = '0, irqPending = '0;
  logic [N*PW-1:0] irqPrio = '0;
  logic [PW-1:0] prioMask = '0;
  logic [PW:0] runPrio = 9'h100;
  logic [IW-1:0] pendId;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int    expIdQ[$];
  bit    expIrqQ[$];
  string reqQ[$];
  int    lastId = 1023;
  bit    lastIrq = 0;

  always #5 clk = ~clk;

  pend_prio_sel #(.NUM_IRQ(N), .PRIO_W(PW), .ID_W(IW)) u_pend_prio_sel (
    .clk(clk), .rst_n(rst_n), .distEnable(distEnable), .cpuEnable(cpuEnable),
    .irqEnable(irqEnable), .irqPending(irqPending), .irqPrio(irqPrio),
    .prioMask(prioMask), .runPrio(runPrio), .pendId(pendId), .irqReq(irqReq)
  );

  // Reference from the requirements.
  task automatic model(output int id, output bit irq);
    int best = 256;
    int bid = 1023;
    for (int i = 0; i < N; i++) begin
      int p = int'(irqPrio[i*PW +: PW]);
      if (irqEnable[i] && irqPending[i] && p < best) begin
        best = p;
        bid = i;
      end
    end
    id = 1023;
    irq = 0;
    if (distEnable && cpuEnable && best <= int'(prioMask)) begin
      id = bid;
      irq = (best < int'(runPrio));
    end
  endtask

  task automatic compare(string req, int gotId, bit gotIrq, int eId, bit eIrq);
    checks++;
    if (gotId != eId || gotIrq != eIrq) begin
      errors++;
      $display("FAIL %s: pendId=%0d irqReq=%0d expected pendId=%0d irqReq=%0d",
               req, gotId, gotIrq, eId, eIrq);
    end
  endtask

  // Driver: inputs already set by caller are applied at a falling edge.
  task automatic push(string req);
    int id;
    bit irq;
    model(id, irq);
    expIdQ.push_back(id);
    expIrqQ.push_back(irq);
    reqQ.push_back(req);
    lastId = id;
    lastIrq = irq;
  endtask

  // Monitor: one edge after the driver's falling edge, outputs are due.
  always @(posedge clk) begin
    #1;
    if (expIdQ.size() > 0) begin
      compare(reqQ.pop_front(), int'(pendId), irqReq,
              expIdQ.pop_front(), expIrqQ.pop_front());
    end
  end

  task automatic setPrio(int i, int p);
    irqPrio[i*PW +: PW] = PW'(p);
  endtask

  task automatic clearAll();
    irqEnable = '0;
    irqPending = '0;
    irqPrio = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset", int'(pendId), irqReq, 1023, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after reset", int'(pendId), irqReq, 1023, 0);

    // R4: enabled, nothing pending
    distEnable = 1; cpuEnable = 1; prioMask = 8'hFF; runPrio = 9'h100;
    push("R4 no candidate");
    @(negedge clk);

    // R1: pending but not enabled
    irqPending[5] = 1; setPrio(5, 8'h30);
    push("R1 pending not enabled");
    @(negedge clk);
    irqEnable[5] = 1;
    push("R1 enabled and pending");
    @(negedge clk);
    irqPending[5] = 0;
    push("R1 enabled not pending");
    @(negedge clk);

    // R2: smallest priority wins
    clearAll();
    irqEnable[10] = 1; irqPending[10] = 1; setPrio(10, 8'h40);
    irqEnable[20] = 1; irqPending[20] = 1; setPrio(20, 8'h20);
    irqEnable[40] = 1; irqPending[40] = 1; setPrio(40, 8'h80);
    push("R2 lowest value");
    @(negedge clk);

    // R3: tie goes to lowest ID
    irqEnable[30] = 1; irqPending[30] = 1; setPrio(30, 8'h20);
    irqEnable[12] = 1; irqPending[12] = 1; setPrio(12, 8'h20);
    push("R3 tie lowest ID");
    @(negedge clk);

    // R5: mask inclusive
    prioMask = 8'h20;
    push("R5 equal to mask");
    @(negedge clk);
    prioMask = 8'h1F;
    push("R5 above mask");
    @(negedge clk);

    // R6: strict preemption
    prioMask = 8'hFF; runPrio = 9'h020;
    push("R6 equal running");
    @(negedge clk);
    runPrio = 9'h021;
    push("R6 below running");
    @(negedge clk);

    // R7: enables
    distEnable = 0;
    push("R7 distributor off");
    @(negedge clk);
    distEnable = 1; cpuEnable = 0;
    push("R7 interface off");
    @(negedge clk);
    cpuEnable = 1;

    // R10 with boundary IDs and priority 0xFF
    clearAll(); runPrio = 9'h100; prioMask = 8'hFF;
    irqEnable[63] = 1; irqPending[63] = 1; setPrio(63, 8'hFF);
    push("R10 idle accepts 0xFF at top ID");
    @(negedge clk);
    irqEnable[0] = 1; irqPending[0] = 1; setPrio(0, 8'hFF);
    push("R3 tie at 0xFF picks ID 0");
    @(negedge clk);

    // R8: a change is not visible before the next edge
    @(negedge clk);
    setPrio(0, 8'h05); runPrio = 9'h004;
    #1;
    compare("R8 no change before edge", int'(pendId), irqReq, lastId, lastIrq);
    push("R8 change after edge");
    @(negedge clk);

    // R2/R3 random patterns with few distinct priorities
    for (int k = 0; k < 300; k++) begin
      irqEnable  = {$urandom(), $urandom()};
      irqPending = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      for (int i = 0; i < N; i++) setPrio(i, ($urandom() % 8) * 32 + 7);
      prioMask = PW'($urandom());
      runPrio = ($urandom() % 4 == 0) ? 9'h100 : 9'($urandom() % 256);
      distEnable = ($urandom() % 8) != 0;
      cpuEnable = ($urandom() % 8) != 0;
      push("R2 R3 random");
      @(negedge clk);
    end

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule